// File: doc/BRIEF.md
# Shift, Rotate and Bit-Manipulation Unit

This block carries out the bit-oriented instruction group of an 8-bit processor on a single operand byte. The operations are rotates (circular and through carry), arithmetic and logical shifts, and the single-bit test, clear and set operations. It also covers the four compact accumulator rotates, which touch fewer flags. The caller supplies the operand byte, the current flag byte, the 2-bit group field, the 3-bit operation or bit-index field, and a compact-form select. The block returns the result byte, a write-enable that says whether the result should be stored, and the updated flag byte. Operand fetch and writeback are handled elsewhere.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears one cycle later on the output stream. A result leaves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the pending result stays on the port unchanged. `in_ready` is high exactly when the output register is empty or is being drained in the same cycle.

Flag byte layout:

| Bit | Flag |
|-----|------|
| 0 | carry |
| 1 | subtract |
| 2 | parity/overflow |
| 4 | half-carry |
| 6 | zero |
| 7 | sign |

Bits 3 and 5 always pass through unchanged.

Top module: `srb_unit`

## Requirements
- R1: For group 0 (`in_group`=0), these are the circular rotates, and the carry bit always receives the bit shifted out.
  - Code 0 (`in_sel`=0) rotates left: old bit 7 goes to both bit 0 and carry.
  - Code 1 rotates right: old bit 0 goes to both bit 7 and carry.
- R2: Group 0 also has the rotates through carry.
  - Code 2 rotates left: the old carry enters bit 0 and old bit 7 becomes the carry.
  - Code 3 rotates right: the old carry enters bit 7 and old bit 0 becomes the carry.
- R3: Group 0 also has the shifts.
  - Code 4 shifts left, inserting 0, with carry set to old bit 7.
  - Code 5 shifts right, keeping bit 7, with carry set to old bit 0.
  - Code 7 shifts right, inserting 0, with carry set to old bit 0.
- R4: Every legal group-0 operation in full form does the following:
  - clears half-carry and subtract;
  - sets sign to result bit 7;
  - sets zero when the result is 0;
  - sets parity/overflow to 1 when the result has an even number of one bits;
  - raises the write-enable.
- R5: When `in_short` is high with group 0 and codes 0 to 3:
  - only carry, half-carry and subtract are updated;
  - sign, zero and parity/overflow keep their input values.

  For any other group or code, `in_short` has no effect.
- R6: Group 0 code 6 is illegal. The write-enable is low, the result equals the operand, and the flags are returned unchanged.
- R7: Group 1 is the bit test, with `in_sel` as the bit index.
  - Zero is set when the selected bit is 0.
  - Half-carry is set and subtract is cleared.
  - All other flags are unchanged.
  - The write-enable is low and the result equals the operand.
- R8: Group 2 clears the bit selected by `in_sel` and group 3 sets it. The write-enable is high and the flag byte is returned unchanged.
- R9: The result of an accepted request is valid on the following cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_wr_en` and `out_flags` hold. Results leave in acceptance order.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_operand | input | 8 | Operand byte |
| in_flags | input | 8 | Incoming flag byte |
| in_group | input | 2 | 0 shift/rotate, 1 bit test, 2 bit clear, 3 bit set |
| in_sel | input | 3 | Operation code (group 0) or bit index (groups 1-3) |
| in_short | input | 1 | Compact accumulator-rotate flag behaviour |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Result byte |
| out_wr_en | output | 1 | Result should be stored |
| out_flags | output | 8 | Updated flag byte |

## Verification
A wrong fill-bit choice or a swapped shift direction shows up one cycle after acceptance, as a wrong `out_result` byte and a wrong carry in `out_flags`. A flag-update mask that is stuck in the compact or full setting shows up in the same cycle on bits 2, 6 and 7. A mask selecting the wrong index shows up as a result or zero flag that disagrees with the chosen bit. Faults in the output holding register show up at the first stall, as a result that changes or vanishes while `out_ready` is low. The bench therefore sweeps every group and code with carry both set and clear, and throttles `out_ready` at random.

// File: rtl/srb_pkg.sv
package srb_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = $clog2(DW);

  // flag byte bit positions
  localparam int F_C  = 0;
  localparam int F_N  = 1;
  localparam int F_PV = 2;
  localparam int F_H  = 4;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL_CIRC = 3'd0,
    SH_ROR_CIRC = 3'd1,
    SH_ROL_CARRY = 3'd2,
    SH_ROR_CARRY = 3'd3,
    SH_SHL_ARITH = 3'd4,
    SH_SHR_ARITH = 3'd5,
    SH_ILLEGAL   = 3'd6,
    SH_SHR_LOGIC = 3'd7
  } shop_e;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          wr;
    logic [DW-1:0] flags;
  } srb_res_t;

  function automatic logic even_ones(input logic [DW-1:0] v);
    return ~(^v);
  endfunction
endpackage

// File: rtl/srb_shift.sv
module srb_shift
  import srb_pkg::*;
(
  input  logic [DW-1:0]    operand,
  input  logic [DW-1:0]    flags_in,
  input  logic [2:0]       code,
  input  logic             compact,
  output srb_res_t         res
);
  logic          go_left;
  logic          fill;
  logic          legal;
  logic          shifted_out;
  logic [DW-1:0] moved;
  logic          full_flags;

  always_comb begin
    go_left = 1'b0;
    fill    = 1'b0;
    legal   = 1'b1;
    unique case (shop_e'(code))
      SH_ROL_CIRC:  begin go_left = 1'b1; fill = operand[DW-1]; end
      SH_ROR_CIRC:  begin go_left = 1'b0; fill = operand[0];    end
      SH_ROL_CARRY: begin go_left = 1'b1; fill = flags_in[F_C]; end
      SH_ROR_CARRY: begin go_left = 1'b0; fill = flags_in[F_C]; end
      SH_SHL_ARITH: begin go_left = 1'b1; fill = 1'b0;          end
      SH_SHR_ARITH: begin go_left = 1'b0; fill = operand[DW-1]; end
      SH_SHR_LOGIC: begin go_left = 1'b0; fill = 1'b0;          end
      default:      begin legal   = 1'b0;                       end
    endcase
  end

  assign moved       = go_left ? {operand[DW-2:0], fill} : {fill, operand[DW-1:1]};
  assign shifted_out = go_left ? operand[DW-1] : operand[0];
  // compact form only exists for the four rotates (code bit 2 clear)
  assign full_flags  = !(compact && !code[2]);

  always_comb begin
    res.flags = flags_in;
    res.data  = operand;
    res.wr    = 1'b0;
    if (legal) begin
      res.data        = moved;
      res.wr          = 1'b1;
      res.flags[F_C]  = shifted_out;
      res.flags[F_H]  = 1'b0;
      res.flags[F_N]  = 1'b0;
      if (full_flags) begin
        res.flags[F_S]  = moved[DW-1];
        res.flags[F_Z]  = (moved == '0);
        res.flags[F_PV] = even_ones(moved);
      end
    end
  end
endmodule

// File: rtl/srb_bitop.sv
module srb_bitop
  import srb_pkg::*;
(
  input  logic [DW-1:0]    operand,
  input  logic [DW-1:0]    flags_in,
  input  logic [1:0]       group,
  input  logic [IDX_W-1:0] index,
  output srb_res_t         res
);
  logic [DW-1:0] mask;

  for (genvar i = 0; i < DW; i++) begin : g_mask
    assign mask[i] = (index == IDX_W'(i));
  end

  logic picked;
  assign picked = |(operand & mask);

  always_comb begin
    res.flags = flags_in;
    res.data  = operand;
    res.wr    = 1'b0;
    unique case (grp_e'(group))
      GRP_TEST: begin
        res.flags[F_Z] = ~picked;
        res.flags[F_H] = 1'b1;
        res.flags[F_N] = 1'b0;
      end
      GRP_CLR: begin
        res.data = operand & ~mask;
        res.wr   = 1'b1;
      end
      GRP_SET: begin
        res.data = operand | mask;
        res.wr   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/srb_unit.sv
module srb_unit
  import srb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [DW-1:0]    in_operand,
  input  logic [DW-1:0]    in_flags,
  input  logic [1:0]       in_group,
  input  logic [IDX_W-1:0] in_sel,
  input  logic             in_short,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_result,
  output logic             out_wr_en,
  output logic [DW-1:0]    out_flags
);
  srb_res_t sh_res, bt_res, pick, held;

  srb_shift u_shift (
    .operand  (in_operand),
    .flags_in (in_flags),
    .code     (in_sel),
    .compact  (in_short),
    .res      (sh_res)
  );

  srb_bitop u_bitop (
    .operand  (in_operand),
    .flags_in (in_flags),
    .group    (in_group),
    .index    (in_sel),
    .res      (bt_res)
  );

  assign pick     = (grp_e'(in_group) == GRP_SHIFT) ? sh_res : bt_res;
  assign in_ready = !out_valid || out_ready;

  logic take;
  assign take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      held      <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     held      <= pick;
    end
  end

  assign out_result = held.data;
  assign out_wr_en  = held.wr;
  assign out_flags  = held.flags;

  // checking support: a request was accepted on the previous edge
  logic took_q;
  always_ff @(posedge clk) begin
    if (!rst_n) took_q <= 1'b0;
    else        took_q <= take;
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
      && $stable(out_flags) && $stable(out_wr_en));

  // R9
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_q |-> out_valid);

  // R4
  shift_hn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_q && $past(in_group) == 2'd0 && $past(in_sel) != 3'd6
      |-> out_wr_en && !out_flags[F_H] && !out_flags[F_N]);

  // R6
  illegal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_q && $past(in_group) == 2'd0 && $past(in_sel) == 3'd6
      |-> !out_wr_en && out_flags == $past(in_flags)
        && out_result == $past(in_operand));

  // R7
  test_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_q && $past(in_group) == 2'd1
      |-> !out_wr_en && out_result == $past(in_operand)
        && out_flags[F_H] && !out_flags[F_N]);

  // R8
  clrset_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_q && $past(in_group[1])
      |-> out_wr_en && out_flags == $past(in_flags));

  // R1 R2 R3
  carry_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    took_q && $past(in_group) == 2'd0 && $past(in_sel) != 3'd6
      |-> out_flags[F_C] == ($past(in_sel[0]) ? $past(in_operand[0])
                                             : $past(in_operand[DW-1])));
endmodule

// File: tb/srb_unit_test.sv
`timescale 1ns/100ps
module srb_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_operand = '0;
  logic [7:0] in_flags = '0;
  logic [1:0] in_group = '0;
  logic [2:0] in_sel = '0;
  logic in_short = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_result;
  logic out_wr_en;
  logic [7:0] out_flags;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit throttle = 1'b0;
  bit driving_done = 1'b0;

  logic [16:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  srb_unit uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_flags(in_flags),
    .in_group(in_group), .in_sel(in_sel), .in_short(in_short),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_wr_en(out_wr_en), .out_flags(out_flags)
  );

  task automatic check(input bit ok, input string req, input logic [16:0] act,
                       input logic [16:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected {wr, result, flags} from the requirement text
  function automatic logic [16:0] model(input logic [1:0] g, input logic [2:0] s,
      input bit sh, input logic [7:0] op, input logic [7:0] fl);
    logic [7:0] r = op;
    logic [7:0] nf = fl;
    logic w = 1'b0;
    logic c = 1'b0;
    if (g == 2'd0) begin
      case (s)
        3'd0: begin r = {op[6:0], op[7]}; c = op[7]; end
        3'd1: begin r = {op[0], op[7:1]}; c = op[0]; end
        3'd2: begin r = {op[6:0], fl[0]}; c = op[7]; end
        3'd3: begin r = {fl[0], op[7:1]}; c = op[0]; end
        3'd4: begin r = {op[6:0], 1'b0};  c = op[7]; end
        3'd5: begin r = {op[7], op[7:1]}; c = op[0]; end
        3'd7: begin r = {1'b0, op[7:1]};  c = op[0]; end
        default: ;
      endcase
      if (s != 3'd6) begin
        w = 1'b1;
        nf[0] = c; nf[4] = 1'b0; nf[1] = 1'b0;
        if (!(sh && s < 3'd4)) begin
          nf[7] = r[7];
          nf[6] = (r == 8'h00);
          nf[2] = ~(^r);
        end
      end
    end else if (g == 2'd1) begin
      nf[6] = ~op[s]; nf[4] = 1'b1; nf[1] = 1'b0;
    end else begin
      w = 1'b1;
      if (g == 2'd2) r[s] = 1'b0; else r[s] = 1'b1;
    end
    return {w, r, nf};
  endfunction

  function automatic string tag_of(input logic [1:0] g, input logic [2:0] s, input bit sh);
    if (g == 2'd1) return "R7";
    if (g != 2'd0) return "R8";
    if (s == 3'd6) return "R6";
    if (sh && s < 3'd4) return "R5";
    if (s < 3'd2) return "R1/R4";
    if (s < 3'd4) return "R2/R4";
    return "R3/R4";
  endfunction

  task automatic send(input logic [1:0] g, input logic [2:0] s, input bit sh,
                      input logic [7:0] op, input logic [7:0] fl);
    @(negedge clk);
    in_valid = 1'b1; in_group = g; in_sel = s; in_short = sh;
    in_operand = op; in_flags = fl;
    #0.4;
    while (!in_ready) begin
      @(negedge clk);
      #0.4;
    end
    exp_q.push_back(model(g, s, sh, op, fl));
    tag_q.push_back(tag_of(g, s, sh));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: set ready, then compare the result that will leave at the next edge
  logic [16:0] prev_out;
  bit prev_stall = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall)
          // R9 stalled result must persist
          check(out_valid && {out_wr_en, out_result, out_flags} == prev_out, "R9",
                {out_wr_en, out_result, out_flags}, prev_out);
        out_ready = throttle ? ($urandom_range(0, 9) < 6) : 1'b1;
        #0.2;
        prev_stall = out_valid && !out_ready;
        prev_out   = {out_wr_en, out_result, out_flags};
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R9", {out_wr_en, out_result, out_flags}, '0);
          end else begin
            logic [16:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({out_wr_en, out_result, out_flags} == e, t,
                  {out_wr_en, out_result, out_flags}, e);
          end
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        check(1'b0, "watchdog", '0, '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] ops [7] = '{8'h00, 8'h80, 8'h01, 8'hA5, 8'h5A, 8'hFF, 8'h3C};
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!out_valid && in_ready, "R10", {15'd0, out_valid, in_ready}, 17'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R10", {15'd0, out_valid, in_ready}, 17'd1);
    // directed: rotate left through carry with carry set, full form
    send(2'd0, 3'd2, 1'b0, 8'h80, 8'h01);
    // directed: illegal code keeps everything
    send(2'd0, 3'd6, 1'b0, 8'h12, 8'h28);
    // directed: bit test on clear bit 3
    send(2'd1, 3'd3, 1'b0, 8'hF7, 8'h00);
    // R5: short ignored for bit set
    send(2'd3, 3'd0, 1'b1, 8'h00, 8'hC4);
    throttle = 1'b1;
    for (int oi = 0; oi < 7; oi++)
      for (int g = 0; g < 4; g++)
        for (int s = 0; s < 8; s++)
          for (int sh = 0; sh < 2; sh++)
            for (int f = 0; f < 2; f++)
              send(g[1:0], s[2:0], sh[0], ops[oi], f[0] ? 8'hFF : 8'h00);
    throttle = 1'b0;
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9", 17'(exp_q.size()), 17'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule